// File: doc/BRIEF.md
# Watchdog Timer with Safe-State Output Override

This block is a down-counting watchdog for an output word that drives field actuators. The host writes a reload value as 16-bit halves, sets an enable bit, and then keeps rewriting the reload registers, or pulsing the interrupt clear, before the count runs out. A one-cycle tick input (nominally 10 MHz, so one count is 100 ns) paces the counter. With a 32-bit counter the timeout runs from zero up to about 429.5 seconds.

When the count reaches zero the block raises a sticky interrupt, and the counter stays at zero. If the safety-output enable bit was set, the output word stops following the host's normal word and shows a stored safety pattern instead. The pattern comes from a bank of 16-bit registers. The override ends only when the host clears the interrupt. Control is a write-only register. Its state can be read back at any time on a separate 4-bit status port.

Top module: `wdt_safe_out`

## Requirements
- R1: After reset the status is 0, the interrupt is low, the count is 0, and out_word_o equals norm_word_i.
- R2: The reload value is written as 16-bit halves: address 0 is bits 15:0 and address 1 is bits 31:16. A control write (address 2) that sets bit 1 while the timer is disabled loads the count with the reload value at that clock edge.
- R3: While enabled, the count drops by one on each clock edge where tick_i is high. When tick_i is low, or the timer is disabled, the count holds.
- R4: With a reload of N, irq_o goes high at the (N+1)th clock edge after the enabling edge. A reload of 0 expires at the next edge.
- R5: After expiry the count stays at 0 and irq_o stays high until a clear or a restart.
- R6: Control bit 2 clears on a write of one. It drops irq_o at that edge and, if the timer stays enabled, reloads the count. A control write with bit 2 at 0 leaves irq_o unchanged.
- R7: Control bit 3 is the safety-output enable. If it is set when the timer expires, out_word_o shows the safety pattern from the next cycle until the interrupt is cleared. The pattern is at addresses 3 to 6, with address 3 as bits 15:0. If bit 3 is clear, out_word_o keeps following norm_word_i.
- R8: status_o bit 0 reports the stored hot-reset hold bit (control bit 0), bit 1 the enable, bit 2 the interrupt, and bit 3 the safety-output enable.
- R9: A write to either reload half while the timer is enabled restarts the count from the full new reload value at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count strobe, one pulse per 100 ns period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| norm_word_i | input | 64 | Output word used when no override is active |
| out_word_o | output | 64 | Output word to the actuators |
| irq_o | output | 1 | Expiry interrupt, sticky |
| status_o | output | 4 | Read-back of hold, enable, interrupt and safety enable |
| count_o | output | 32 | Present counter value |

## Verification
The hardest state to reach is a counter that crossed the 16-bit boundary. It only happens when both reload halves are programmed, and it takes tens of thousands of ticks to drain. One table row loads 0x00010002 and lets the counter run all the way to expiry.

Another hard case is a reload write that lands while the timer is mid-count. The stimulus lines that write up with a known tick count, so the restart value can be checked exactly. The safety override is also hard to observe, because it shows only after a real expiry. The bench therefore writes a distinct pattern into every safety word and compares the whole output word before and after the clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // control word bit positions (behavioural: status mirrors them)
   localparam int unsigned CB_HOLD  = 0;
   localparam int unsigned CB_EN    = 1;
   localparam int unsigned CB_CLR   = 2;
   localparam int unsigned CB_SAFE  = 3;
   localparam int unsigned CTRL_W   = 4;

   typedef struct packed {
      logic safe_en;
      logic irq;
      logic en;
      logic hold;
   } wdt_status_t;
endpackage

// File: rtl/wdt_load_regs.sv
module wdt_load_regs #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned REG_W  = 16,
   parameter int unsigned OUT_W  = 64,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   output logic [CNT_W-1:0]  reload_nxt_o,
   output logic              reload_wr_o,
   output logic [OUT_W-1:0]  safe_word_o
);
   localparam int unsigned HALVES    = CNT_W / REG_W;
   localparam int unsigned SAFE_N    = OUT_W / REG_W;
   localparam int unsigned SAFE_BASE = HALVES + 1;

   logic [HALVES-1:0] half_hit;
   logic [CNT_W-1:0]  reload_q;

   for (genvar g = 0; g < HALVES; g++) begin : g_half
      assign half_hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
      always_ff @(posedge clk_i) begin
         if (!rst_n_i)         reload_q[g*REG_W +: REG_W] <= '0;
         else if (half_hit[g]) reload_q[g*REG_W +: REG_W] <= wr_data_i;
      end
      assign reload_nxt_o[g*REG_W +: REG_W] =
         half_hit[g] ? wr_data_i : reload_q[g*REG_W +: REG_W];
   end

   assign reload_wr_o = |half_hit;

   for (genvar s = 0; s < SAFE_N; s++) begin : g_safe
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == ADDR_W'(SAFE_BASE + s));
      always_ff @(posedge clk_i) begin
         if (!rst_n_i) safe_word_o[s*REG_W +: REG_W] <= '0;
         else if (hit) safe_word_o[s*REG_W +: REG_W] <= wr_data_i;
      end
   end

   // R2: a reload half write is visible in the next-value view in the same cycle
   assert_half_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wr_en_i && wr_addr_i == '0) |-> reload_nxt_o[REG_W-1:0] == wr_data_i);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              ctrl_wr_i,
   input  logic [CTRL_W-1:0] ctrl_d_i,
   input  logic              reload_wr_i,
   input  logic              cnt_zero_i,
   output wdt_status_t       stat_o,
   output logic              safe_act_o,
   output logic              restart_o
);
   logic hold_q, en_q, safe_q, irq_q, armed_q, safe_act_q;
   logic en_nxt, clr_wr, rise_wr, expire;

   assign en_nxt    = ctrl_wr_i ? ctrl_d_i[CB_EN] : en_q;
   assign clr_wr    = ctrl_wr_i && ctrl_d_i[CB_CLR];
   assign rise_wr   = ctrl_wr_i && ctrl_d_i[CB_EN] && !en_q;
   assign restart_o = en_nxt && (rise_wr || reload_wr_i || clr_wr);
   assign expire    = en_q && armed_q && cnt_zero_i && !restart_o && !clr_wr;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         hold_q     <= 1'b0;
         en_q       <= 1'b0;
         safe_q     <= 1'b0;
         irq_q      <= 1'b0;
         armed_q    <= 1'b0;
         safe_act_q <= 1'b0;
      end else begin
         if (ctrl_wr_i) begin
            hold_q <= ctrl_d_i[CB_HOLD];
            en_q   <= ctrl_d_i[CB_EN];
            safe_q <= ctrl_d_i[CB_SAFE];
         end
         if (clr_wr) begin
            irq_q      <= 1'b0;
            safe_act_q <= 1'b0;
         end else if (expire) begin
            irq_q <= 1'b1;
            if (safe_q) safe_act_q <= 1'b1;
         end
         if (restart_o)   armed_q <= 1'b1;
         else if (expire) armed_q <= 1'b0;
      end
   end

   assign stat_o.hold    = hold_q;
   assign stat_o.en      = en_q;
   assign stat_o.irq     = irq_q;
   assign stat_o.safe_en = safe_q;
   assign safe_act_o     = safe_act_q;

   // R6: write-one clear drops the interrupt
   assert_clear_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ctrl_wr_i && ctrl_d_i[CB_CLR]) |=> !stat_o.irq);
   // R6: control write with clear bit at zero keeps a pending interrupt
   assert_zero_no_effect_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ctrl_wr_i && !ctrl_d_i[CB_CLR] && stat_o.irq) |=> stat_o.irq);
   // R7: override never active without an interrupt
   assert_override_needs_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      safe_act_o |-> stat_o.irq);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   assign zero_o = (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)                      cnt_q <= '0;
      else if (restart_i)                cnt_q <= reload_i;
      else if (en_i && tick_i && !zero_o) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign cnt_o = cnt_q;

   // R3: one tick, one step down
   assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en_i && tick_i && cnt_o != '0 && !restart_i) |=> cnt_o == $past(cnt_o) - CNT_W'(1));
   // R3: no tick or disabled means the count holds
   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((!tick_i || !en_i) && !restart_i) |=> $stable(cnt_o));
endmodule

// File: rtl/wdt_safe_out.sv
module wdt_safe_out
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned REG_W   = 16,
   parameter int unsigned OUT_W   = 64,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [OUT_W-1:0]  norm_word_i,
   output logic [OUT_W-1:0]  out_word_o,
   output logic              irq_o,
   output logic [CTRL_W-1:0] status_o,
   output logic [CNT_W-1:0]  count_o
);
   localparam int unsigned HALVES    = CNT_W / REG_W;
   localparam int unsigned CTRL_ADDR = HALVES;
   localparam int unsigned LAST_ADDR = HALVES + OUT_W / REG_W;

   if (CNT_W % REG_W != 0) begin : g_bad_cnt
      $error("CNT_W must be a multiple of REG_W");
   end
   if (OUT_W % REG_W != 0) begin : g_bad_out
      $error("OUT_W must be a multiple of REG_W");
   end
   if (REG_W < CTRL_W) begin : g_bad_reg
      $error("REG_W too narrow for the control bits");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [CNT_W-1:0] reload_nxt;
   logic             reload_wr, restart, cnt_zero, safe_act, ctrl_wr;
   logic [OUT_W-1:0] safe_word;
   wdt_status_t      stat;

   assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

   wdt_load_regs #(.CNT_W(CNT_W), .REG_W(REG_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i, .rst_n_i, .wr_en_i, .wr_addr_i, .wr_data_i,
      .reload_nxt_o (reload_nxt),
      .reload_wr_o  (reload_wr),
      .safe_word_o  (safe_word)
   );

   wdt_ctrl u_ctrl (
      .clk_i, .rst_n_i,
      .ctrl_wr_i   (ctrl_wr),
      .ctrl_d_i    (wr_data_i[CTRL_W-1:0]),
      .reload_wr_i (reload_wr),
      .cnt_zero_i  (cnt_zero),
      .stat_o      (stat),
      .safe_act_o  (safe_act),
      .restart_o   (restart)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_n_i, .tick_i,
      .en_i      (stat.en),
      .restart_i (restart),
      .reload_i  (reload_nxt),
      .cnt_o     (count_o),
      .zero_o    (cnt_zero)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i) begin
         if (!rst_n_i) out_word_o <= '0;
         else          out_word_o <= safe_act ? safe_word : norm_word_i;
      end
   end else begin : g_out_comb
      assign out_word_o = safe_act ? safe_word : norm_word_i;
      // R7: no override means the normal word passes through
      assert_pass_through_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         !irq_o |-> out_word_o == norm_word_i);
   end

   assign irq_o    = stat.irq;
   assign status_o = stat;

   // R4: the interrupt only rises after the count sat at zero
   assert_irq_after_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(irq_o) |-> $past(count_o) == '0);
   // R5: an expired timer stays at zero unless restarted
   assert_stop_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (irq_o && count_o == '0 && !restart) |=> count_o == '0);
   // R9: reload write while enabled restarts the count
   assert_reload_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (reload_wr && status_o[1] && !(ctrl_wr && !wr_data_i[1])) |=> count_o == $past(reload_nxt));
endmodule

// File: tb/wdt_safe_out_tb.sv
module wdt_safe_out_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 150000;
   localparam int NV         = 6;
   localparam logic [63:0] NORM = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] SAFE = 64'hA5A3_A5A2_A5A1_A5A0;
   // {safety enable, reload}
   localparam logic [32:0] VEC [NV] = '{
      {1'b1, 32'd0}, {1'b0, 32'd1}, {1'b1, 32'd2},
      {1'b0, 32'd5}, {1'b1, 32'd37}, {1'b1, 32'h0001_0002}
   };

   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [63:0] out_word;
   logic        irq;
   logic [3:0]  status;
   logic [31:0] count;
   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_safe_out u_dut (
      .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .norm_word_i(NORM),
      .out_word_o(out_word), .irq_o(irq), .status_o(status), .count_o(count)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // call at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", 64'(status), 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);
      chk("R1 count", 64'(count), 64'h0);
      chk("R1 out", out_word, NORM);

      for (int s = 0; s < 4; s++) wr(4'(3 + s), 16'hA5A0 + 16'(s));

      // table walk: R2 load, R4 expiry timing, R7 override, R6 clear
      for (int v = 0; v < NV; v++) begin
         logic [31:0] n;
         logic        se;
         n  = VEC[v][31:0];
         se = VEC[v][32];
         wr(4'd0, n[15:0]);
         wr(4'd1, n[31:16]);
         wr(4'd2, {12'h0, se, 3'b010});
         chk("R2 load", 64'(count), 64'(n));
         repeat (n) @(negedge clk);
         chk("R4 not yet", 64'(irq), 64'h0);
         chk("R3 reached zero", 64'(count), 64'h0);
         @(negedge clk);
         chk("R4 expired", 64'(irq), 64'h1);
         chk("R7 out on expiry", out_word, se ? SAFE : NORM);
         wr(4'd2, 16'h0004);
         chk("R6 cleared", 64'(irq), 64'h0);
         chk("R7 out after clear", out_word, NORM);
      end

      // R9 restart on reload write while enabled
      wr(4'd0, 16'd10);
      wr(4'd1, 16'd0);
      wr(4'd2, 16'h0002);
      repeat (4) @(negedge clk);
      chk("R3 counting", 64'(count), 64'd6);
      wr(4'd0, 16'd20);
      chk("R9 restart", 64'(count), 64'd20);
      // R3 tick low holds
      tick = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3 tick low", 64'(count), 64'd20);
      wr(4'd2, 16'h0000);
      tick = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3 disabled", 64'(count), 64'd20);
      // R8 status, R5 stop at zero, R6 write-zero
      wr(4'd2, 16'h000B);
      chk("R8 status", 64'(status), 64'hB);
      chk("R2 re-enable load", 64'(count), 64'd20);
      repeat (21) @(negedge clk);
      chk("R4 irq", 64'(irq), 64'h1);
      repeat (10) @(negedge clk);
      chk("R5 count stays", 64'(count), 64'h0);
      chk("R5 irq stays", 64'(irq), 64'h1);
      chk("R8 status irq", 64'(status), 64'hF);
      chk("R7 override", out_word, SAFE);
      wr(4'd2, 16'h000B);
      chk("R6 zero no effect", 64'(irq), 64'h1);
      chk("R6 zero no restart", 64'(count), 64'h0);
      wr(4'd2, 16'h000F);
      chk("R6 clear", 64'(irq), 64'h0);
      chk("R6 restart", 64'(count), 64'd20);
      chk("R7 released", out_word, NORM);

      done = 1;
      finish_run();
   end
endmodule